// File: doc/BRIEF.md
# Filtered Trigger Edge Qualifier

This block conditions two asynchronous inputs for a timer that runs in the local clock domain. The first is a clock-like count input. The second is a trigger taken from one of eight candidate sources. Each input first crosses into the timer domain through a two-flop synchronizer. It then passes a digital glitch filter, which accepts a new level only after that level has held for a selectable number of clock periods. Last, an edge picker turns each accepted transition of the chosen polarity into a single-cycle pulse. The timer core uses `cnt_pulse` as its count enable and `trig_pulse` as its start or restart request.

All configuration arrives as static input fields and has no handshake. The fields are meant to change only while the inputs are quiet. A change of the trigger source select is seen by the filter as an ordinary level change, so it can produce a trigger event if the two sources differ. Nothing here flows as a stream: every port is a plain level or a single-cycle strobe with no back-pressure. The filtered levels are also brought out, so the timer can read the settled state of each input.

Top module: `trig_edge_qual`

## Requirements
- R1: Let W = 1, 2, 4 or 8 for filter code 0, 1, 2 or 3. A level change present at an input before rising clock edge k=0, and held, updates the filtered level and raises the pulse at edge k=1+W. The pulse is therefore seen in the cycle that follows the (W+2)-th rising edge.
- R2: With filter code 1, 2 or 3, a raw level change that reverts after fewer than W clock periods changes neither the filtered level nor any pulse output. A change that reverts also restarts the stability count, so a later held change still needs a full W periods.
- R3: The count filter code `cnt_flt` and the trigger filter code `trig_flt` act independently of each other, even when both inputs change in the same cycle.
- R4: Count edge code `cnt_edge`: 0 pulses on accepted rising transitions only, 1 on falling only, and 2 or 3 on both.
- R5: Trigger edge code `trig_edge`: 0 disables trigger pulses (the filtered trigger level still follows the input), 1 selects rising, 2 falling, 3 both.
- R6: The trigger path uses only `trig_src[trig_sel]`. Activity on the unselected sources changes neither `trig_pulse` nor `trig_level`.
- R7: Each accepted active transition yields exactly one pulse, one clock cycle wide.
- R8: After reset is released, no pulse is produced for an input that holds its level. By the fourth rising edge each filtered level equals its input level.
- R9: `cnt_level` and `trig_level` show the filtered level that the last accepted transition committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_in | input | 1 | Asynchronous count input |
| trig_src | input | 8 | Asynchronous trigger candidates |
| trig_sel | input | 3 | Index of the trigger candidate in use |
| cnt_flt | input | 2 | Count filter code (0 none, 1/2/3 = 2/4/8 stable clocks) |
| trig_flt | input | 2 | Trigger filter code, same encoding |
| cnt_edge | input | 2 | Count active edge (0 rise, 1 fall, 2/3 both) |
| trig_edge | input | 2 | Trigger active edge (0 off, 1 rise, 2 fall, 3 both) |
| cnt_pulse | output | 1 | Single-cycle qualified count event |
| trig_pulse | output | 1 | Single-cycle qualified trigger event |
| cnt_level | output | 1 | Filtered count input level |
| trig_level | output | 1 | Filtered selected trigger level |

## Verification
The bench measures the exact latency for every filter code, because a filter that is off by one in its window or an extra stage in the path would move the pulse by a cycle. It sends glitches one period shorter than the window, and a glitch followed by a held change. A filter that failed to restart its count would accept the glitch, or fire early on the later change. Holding the inputs high through reset catches a design that starts its filtered level at zero and so reports a false rising edge. The tests on source selection and edge codes look for toggles on unselected sources that leak through, for the wrong polarity decode, and for a disabled trigger that still fires.

// File: rtl/trig_qual_pkg.sv
package trig_qual_pkg;

  typedef enum logic [1:0] {
    CNT_RISE = 2'd0,
    CNT_FALL = 2'd1,
    CNT_BOTH = 2'd2,
    CNT_BOTH_ALT = 2'd3
  } cnt_edge_e;

  typedef enum logic [1:0] {
    TRG_OFF  = 2'd0,
    TRG_RISE = 2'd1,
    TRG_FALL = 2'd2,
    TRG_BOTH = 2'd3
  } trg_edge_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_en_t;

  // Count codes: 0 rise only, 1 fall only, 2 and 3 both.
  function automatic edge_en_t cnt_edge_decode(input logic [1:0] code);
    edge_en_t e;
    e.rise = (code != CNT_FALL);
    e.fall = (code != CNT_RISE);
    return e;
  endfunction

  // Trigger codes: 0 off, 1 rise, 2 fall, 3 both.
  function automatic edge_en_t trg_edge_decode(input logic [1:0] code);
    edge_en_t e;
    e.rise = (code == TRG_RISE) || (code == TRG_BOTH);
    e.fall = (code == TRG_FALL) || (code == TRG_BOTH);
    return e;
  endfunction

endpackage

// File: rtl/tq_sync.sv
module tq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/tq_glitch_filter.sv
module tq_glitch_filter #(
  parameter int CODE_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic              s,
  input  logic [CODE_W-1:0] code,
  output logic              lvl,
  output logic              chg
);

  localparam int WIN_W = CNT_W + 1;

  logic [CNT_W-1:0] run;
  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] run_next;

  // Window length is a power of two: code 0 -> 1 period (immediate).
  assign win      = WIN_W'(1) << code;
  assign run_next = {1'b0, run} + WIN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      run <= '0;
      chg <= 1'b0;
    end else if (!live) begin
      lvl <= s;
      run <= '0;
      chg <= 1'b0;
    end else begin
      chg <= 1'b0;
      if (s == lvl) begin
        run <= '0;
      end else if (run_next >= win) begin
        lvl <= s;
        run <= '0;
        chg <= 1'b1;
      end else begin
        run <= run_next[CNT_W-1:0];
      end
    end
  end

  AST_FLT_STABLE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(live) && code != '0 && lvl != $past(lvl))
      |-> ($past(s) == lvl && $past(s, 2) == lvl)) // R2
    else $error("filter accepted a level that was not held");

  AST_FLT_QUIET_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> !chg) // R8
    else $error("filter reported a change while priming");

endmodule

// File: rtl/tq_edge_pick.sv
module tq_edge_pick (
  input  logic chg,
  input  logic lvl,
  input  logic rise_en,
  input  logic fall_en,
  output logic pulse
);

  assign pulse = chg & ((lvl & rise_en) | (~lvl & fall_en));

endmodule

// File: rtl/trig_edge_qual.sv
module trig_edge_qual
  import trig_qual_pkg::*;
#(
  parameter int NUM_TRIG    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FLT_CODE_W  = 2,
  parameter int FLT_CNT_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cnt_in,
  input  logic [NUM_TRIG-1:0]         trig_src,
  input  logic [$clog2(NUM_TRIG)-1:0] trig_sel,
  input  logic [FLT_CODE_W-1:0]       cnt_flt,
  input  logic [FLT_CODE_W-1:0]       trig_flt,
  input  logic [1:0]                  cnt_edge,
  input  logic [1:0]                  trig_edge,
  output logic                        cnt_pulse,
  output logic                        trig_pulse,
  output logic                        cnt_level,
  output logic                        trig_level
);

  localparam int LIVE_AT = SYNC_STAGES + 1;
  localparam int LIVE_W  = $clog2(LIVE_AT + 1);

  logic [LIVE_W-1:0]   prime;
  logic                live;
  logic                cnt_s;
  logic [NUM_TRIG-1:0] trig_s_all;
  logic                trig_s;
  logic                cnt_chg;
  logic                trig_chg;
  edge_en_t            cnt_en;
  edge_en_t            trig_en;

  // Priming: filters copy the synchronized level until it is valid.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     prime <= '0;
    else if (prime != LIVE_W'(LIVE_AT)) prime <= prime + LIVE_W'(1);
  end
  assign live = (prime == LIVE_W'(LIVE_AT));

  tq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_in), .q(cnt_s)
  );

  tq_sync #(.WIDTH(NUM_TRIG), .STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .d(trig_src), .q(trig_s_all)
  );

  assign trig_s = trig_s_all[trig_sel];

  tq_glitch_filter #(.CODE_W(FLT_CODE_W), .CNT_W(FLT_CNT_W)) u_cnt_flt (
    .clk(clk), .rst_n(rst_n), .live(live), .s(cnt_s), .code(cnt_flt),
    .lvl(cnt_level), .chg(cnt_chg)
  );

  tq_glitch_filter #(.CODE_W(FLT_CODE_W), .CNT_W(FLT_CNT_W)) u_trig_flt (
    .clk(clk), .rst_n(rst_n), .live(live), .s(trig_s), .code(trig_flt),
    .lvl(trig_level), .chg(trig_chg)
  );

  assign cnt_en  = cnt_edge_decode(cnt_edge);
  assign trig_en = trg_edge_decode(trig_edge);

  tq_edge_pick u_cnt_edge (
    .chg(cnt_chg), .lvl(cnt_level), .rise_en(cnt_en.rise),
    .fall_en(cnt_en.fall), .pulse(cnt_pulse)
  );

  tq_edge_pick u_trig_edge (
    .chg(trig_chg), .lvl(trig_level), .rise_en(trig_en.rise),
    .fall_en(trig_en.fall), .pulse(trig_pulse)
  );

  AST_CNT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> !cnt_pulse) // R7
    else $error("count pulse wider than one cycle");

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse) // R7
    else $error("trigger pulse wider than one cycle");

  AST_CNT_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |-> (cnt_level != $past(cnt_level))) // R1
    else $error("count pulse without a filtered transition");

  AST_CNT_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && cnt_edge == CNT_RISE) |-> cnt_level) // R4
    else $error("rising-only count pulse on a falling transition");

  AST_TRIG_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_edge == TRG_OFF) |-> !trig_pulse) // R5
    else $error("trigger pulse while trigger is disabled");

endmodule

// File: tb/trig_edge_qual_bench.sv
`timescale 1ns/1ps
module trig_edge_qual_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_in = 1'b1;
  logic [7:0] trig_src = 8'h01;
  logic [2:0] trig_sel = 3'd0;
  logic [1:0] cnt_flt = 2'd0;
  logic [1:0] trig_flt = 2'd0;
  logic [1:0] cnt_edge = 2'd2;
  logic [1:0] trig_edge = 2'd3;
  logic       cnt_pulse, trig_pulse, cnt_level, trig_level;

  int checks = 0;
  int errors = 0;
  int ch_hits, ch_first, tr_hits, tr_first;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trig_edge_qual u_trig_edge_qual (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .trig_src(trig_src),
    .trig_sel(trig_sel), .cnt_flt(cnt_flt), .trig_flt(trig_flt),
    .cnt_edge(cnt_edge), .trig_edge(trig_edge), .cnt_pulse(cnt_pulse),
    .trig_pulse(trig_pulse), .cnt_level(cnt_level), .trig_level(trig_level)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Samples n falling edges; index 1 is the first falling edge after the call.
  task automatic observe(input int n);
    ch_hits = 0; ch_first = 0; tr_hits = 0; tr_first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (cnt_pulse) begin
        if (ch_hits == 0) ch_first = i;
        ch_hits++;
      end
      if (trig_pulse) begin
        if (tr_hits == 0) tr_first = i;
        tr_hits++;
      end
    end
  endtask

  task automatic settle();
    observe(24);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    observe(8);
    chk(ch_hits == 0, "R8 count quiet after reset", ch_hits, 0);
    chk(tr_hits == 0, "R8 trigger quiet after reset", tr_hits, 0);
    chk(cnt_level == 1'b1, "R8 count level primed", cnt_level, 1);
    chk(trig_level == 1'b1, "R8 trigger level primed", trig_level, 1);
  endtask

  task automatic t_latency();
    cnt_edge = 2'd0;
    for (int code = 0; code < 4; code++) begin
      cnt_flt = 2'(code);
      cnt_in = 1'b0;
      settle();
      cnt_in = 1'b1;
      observe(16);
      chk(ch_hits == 1, "R7 single count pulse", ch_hits, 1);
      chk(ch_first == (1 << code) + 2, "R1 count latency", ch_first, (1 << code) + 2);
      chk(cnt_level == 1'b1, "R9 count level after rise", cnt_level, 1);
    end
  endtask

  task automatic t_glitch();
    cnt_edge = 2'd2;
    for (int code = 1; code < 4; code++) begin
      cnt_flt = 2'(code);
      cnt_in = 1'b0;
      settle();
      cnt_in = 1'b1;
      repeat ((1 << code) - 1) @(negedge clk);
      cnt_in = 1'b0;
      observe(20);
      chk(ch_hits == 0, "R2 short glitch rejected", ch_hits, 0);
      chk(cnt_level == 1'b0, "R2 level kept after glitch", cnt_level, 0);
      @(negedge clk);
      cnt_in = 1'b1;
      repeat ((1 << code) - 1) @(negedge clk);
      cnt_in = 1'b0;
      @(negedge clk);
      cnt_in = 1'b1;
      observe(16);
      chk(ch_first == (1 << code) + 2, "R2 window restarts", ch_first, (1 << code) + 2);
    end
  endtask

  task automatic t_cnt_edges();
    cnt_flt = 2'd0;
    for (int e = 1; e < 4; e++) begin
      cnt_edge = 2'(e);
      cnt_in = 1'b0;
      settle();
      cnt_in = 1'b1;
      observe(8);
      chk(ch_hits == ((e == 1) ? 0 : 1), "R4 count rise", ch_hits, (e == 1) ? 0 : 1);
      cnt_in = 1'b0;
      observe(8);
      chk(ch_hits == 1, "R4 count fall", ch_hits, 1);
    end
  endtask

  task automatic t_trig_modes();
    trig_flt = 2'd0;
    trig_sel = 3'd3;
    for (int e = 0; e < 4; e++) begin
      trig_edge = 2'(e);
      trig_src = 8'h00;
      settle();
      trig_src[3] = 1'b1;
      observe(8);
      chk(tr_hits == (e & 1), "R5 trigger rise", tr_hits, e & 1);
      chk(trig_level == 1'b1, "R5 trigger level follows", trig_level, 1);
      trig_src[3] = 1'b0;
      observe(8);
      chk(tr_hits == ((e >> 1) & 1), "R5 trigger fall", tr_hits, (e >> 1) & 1);
    end
  endtask

  task automatic t_trig_select();
    trig_edge = 2'd3;
    trig_sel = 3'd5;
    trig_src = 8'h00;
    settle();
    trig_src[2] = 1'b1;
    trig_src[7] = 1'b1;
    observe(12);
    chk(tr_hits == 0, "R6 unselected source ignored", tr_hits, 0);
    chk(trig_level == 1'b0, "R6 level unaffected", trig_level, 0);
    trig_src[5] = 1'b1;
    observe(8);
    chk(tr_hits == 1, "R6 selected source pulses", tr_hits, 1);
    chk(tr_first == 3, "R6 selected source latency", tr_first, 3);
  endtask

  task automatic t_independent();
    cnt_flt = 2'd3;
    trig_flt = 2'd1;
    cnt_edge = 2'd0;
    trig_edge = 2'd1;
    trig_sel = 3'd0;
    cnt_in = 1'b0;
    trig_src = 8'h00;
    settle();
    cnt_in = 1'b1;
    trig_src[0] = 1'b1;
    observe(16);
    chk(tr_first == 4, "R3 trigger uses its own window", tr_first, 4);
    chk(ch_first == 10, "R3 count uses its own window", ch_first, 10);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_glitch();
    t_cnt_edges();
    t_trig_modes();
    t_trig_select();
    t_independent();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule